// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms 32-bit linear addresses for a processor core that uses a segmented memory model. It holds the base addresses of six segments (code, data, stack, extra, and two auxiliary data segments) together with the stack pointer and the instruction pointer. Each cycle the core presents an operation code with an offset and some addressing-mode qualifiers. The unit picks a segment and adds its base to the right offset. It also updates the pointers that the operation implies.

The segment is picked in one of two ways. Implicit rules decide it from the kind of access, or an explicit override input replaces the default for plain data and string accesses. Stack accesses decrement the pointer before the access and increment it after. Instruction fetches always use the code segment with the instruction pointer. String accesses also return the next element pointer, which steps up or down under the direction flag. The unit does no protection checks, has no descriptor tables and makes no memory access. It only produces addresses and the updated pointers.

Top module: `seg_addr_unit`

## Requirements
- R1: While rst_n is low at a rising edge, all six segment bases become 0, the stack pointer becomes SP_RESET (default 0) and the instruction pointer becomes IP_RESET (default 0x0000FFF0).
- R2: With seg_wr_en high, a seg_wr_sel of 1 (data), 2 (stack), 3 (extra), 4 (aux0) or 5 (aux1) loads seg_wr_base into that base at the next edge. A seg_wr_sel of 0 (code), 6 or 7 changes no base.
- R3: The code base changes only when cs_load is high. At that edge it takes cs_base_in and the instruction pointer takes ip_load_val, and cs_load wins over ip_advance.
- R4: With ip_advance high and cs_load low, the instruction pointer grows by ip_len (4 bits) at the next edge. With both low it holds.
- R5: op 1 (fetch) gives lin_addr = code base + instruction pointer, whatever the override inputs are.
- R6: op 2 (memory) and op 5 (string) use the override segment when ovr_valid is high and ovr_sel is 0..5, with the numbering of R2 and 0 meaning code. Otherwise they use the stack segment when base_is_frame is high, and the data segment if not. An ovr_sel of 6 or 7 falls back to these defaults. lin_addr is that base + offset.
- R7: op 3 (push) gives lin_addr = stack base + (sp - step) and sets sp to sp - step at the next edge. step is 4 when acc_size[2] is set and 2 otherwise, and any override is ignored.
- R8: op 4 (pop) gives lin_addr = stack base + sp and sets sp to sp + step at the next edge. Every other op leaves sp unchanged.
- R9: str_ptr_next is offset + acc_size when flags bit 10 is clear and offset - acc_size when it is set (element sizes 1, 2, 4).
- R10: All additions and subtractions wrap modulo 2^32, with no fault indication.
- R11: addr_valid is high exactly when op is 1..5. op 0 (idle) drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Explicit segment base load strobe |
| seg_wr_sel | input | 3 | Segment chosen for the explicit load |
| seg_wr_base | input | 32 | Base value for the explicit load |
| cs_load | input | 1 | Control-transfer load of code base and instruction pointer |
| cs_base_in | input | 32 | New code segment base |
| ip_load_val | input | 32 | New instruction pointer |
| ip_advance | input | 1 | Advance the instruction pointer |
| ip_len | input | 4 | Bytes to advance the instruction pointer |
| op | input | 3 | Operation: 0 idle, 1 fetch, 2 memory, 3 push, 4 pop, 5 string |
| base_is_frame | input | 1 | The addressing mode uses the frame base pointer |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 3 | Override segment number |
| offset | input | 32 | Effective offset for memory and string accesses |
| acc_size | input | 3 | Access size in bytes |
| flags | input | 32 | Flags word, bit 10 is the direction flag |
| lin_addr | output | 32 | Linear address |
| addr_valid | output | 1 | lin_addr belongs to an active operation |
| str_ptr_next | output | 32 | Stepped string pointer |
| sp | output | 32 | Current stack pointer |
| ip | output | 32 | Current instruction pointer |

## Verification
On every cycle the assertions check the pointer steps: a push lowers sp by the step and a pop raises it, and sp holds otherwise. They also check that the instruction pointer follows a control-transfer load and holds when idle, that the code base holds without cs_load, and that a stack-base load lands. The bench's scenarios are needed to show segment choice: override priority over the frame-base and data defaults, overrides ignored on stack operations, and fallback for out-of-range override codes. They also show the direction-flag stepping of string pointers and wrap-around at the 2^32 boundary.

// File: rtl/agu_pkg.sv
// Shared encodings for the segmented address generation unit.
// Assumes segment numbers fit in three bits.
package agu_pkg;
    localparam int NUM_SEG = 6;

    typedef enum logic [2:0] {
        SEG_CODE  = 3'd0,
        SEG_DATA  = 3'd1,
        SEG_STACK = 3'd2,
        SEG_EXTRA = 3'd3,
        SEG_AUX0  = 3'd4,
        SEG_AUX1  = 3'd5
    } seg_e;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_FETCH  = 3'd1,
        OP_MEM    = 3'd2,
        OP_PUSH   = 3'd3,
        OP_POP    = 3'd4,
        OP_STRING = 3'd5
    } op_e;
endpackage

// File: rtl/agu_seg_base_file.sv
// Holds one base address per segment. The code base is written only by
// the control-transfer path; the other bases only by the explicit load.
// Assumes rd_sel is always a valid segment number (0..NSEG-1).
module agu_seg_base_file #(
    parameter int AW   = 32,
    parameter int NSEG = agu_pkg::NUM_SEG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_base,
    input  logic          cs_load,
    input  logic [AW-1:0] cs_base,
    input  logic [2:0]    rd_sel,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] code_base
);
    import agu_pkg::*;

    logic [AW-1:0] bases [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g == int'(SEG_CODE)) begin : g_code
            // Code base: loaded only on a control transfer.
            always_ff @(posedge clk) begin
                if (!rst_n)       bases[g] <= '0;
                else if (cs_load) bases[g] <= cs_base;
            end
        end else begin : g_data
            // Data/stack bases: loaded by the explicit load strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 bases[g] <= '0;
                else if (wr_en && (int'(wr_sel) == g))      bases[g] <= wr_base;
            end
        end
    end

    // Read port: pick the base of the selected segment.
    always_comb begin
        rd_base = bases[int'(SEG_DATA)];
        for (int i = 0; i < NSEG; i++)
            if (int'(rd_sel) == i) rd_base = bases[i];
    end

    assign code_base = bases[int'(SEG_CODE)];

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_load |=> $stable(code_base)); // R3
    AST_STACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEG_STACK) |=> bases[int'(SEG_STACK)] == $past(wr_base)); // R2
endmodule

// File: rtl/agu_seg_select.sv
// Chooses the segment for an access. Fetch uses code and stack
// operations use stack, with no override. Memory and string accesses
// take a valid override first, then the frame-base default, then data.
// Assumes the override code is meaningful only when it is below NSEG.
module agu_seg_select #(
    parameter int NSEG = agu_pkg::NUM_SEG
) (
    input  logic [2:0] op,
    input  logic       base_is_frame,
    input  logic       ovr_valid,
    input  logic [2:0] ovr_sel,
    output logic [2:0] sel
);
    import agu_pkg::*;

    logic ovr_ok;
    assign ovr_ok = ovr_valid && (int'(ovr_sel) < NSEG);

    // Implicit and override segment selection.
    always_comb begin
        case (op)
            OP_FETCH:        sel = SEG_CODE;
            OP_PUSH, OP_POP: sel = SEG_STACK;
            default: begin
                if (ovr_ok)             sel = ovr_sel;
                else if (base_is_frame) sel = SEG_STACK;
                else                    sel = SEG_DATA;
            end
        endcase
    end
endmodule

// File: rtl/agu_ptr_seq.sv
// Stack and instruction pointer registers. A push uses the decremented
// pointer and a pop uses the current one, incrementing afterwards.
// Assumes at most one of op_push and op_pop is high.
module agu_ptr_seq #(
    parameter int          AW       = 32,
    parameter int          LW       = 4,
    parameter logic [AW-1:0] SP_RESET = '0,
    parameter logic [AW-1:0] IP_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_push,
    input  logic          op_pop,
    input  logic          wide,
    input  logic          cs_load,
    input  logic [AW-1:0] ip_load_val,
    input  logic          ip_advance,
    input  logic [LW-1:0] ip_len,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] ip_q,
    output logic [AW-1:0] sp_dec
);
    logic [AW-1:0] step;
    logic [AW-1:0] sp_inc;

    assign step   = wide ? AW'(4) : AW'(2);
    assign sp_dec = sp_q - step;
    assign sp_inc = sp_q + step;

    // Stack pointer: pre-decrement on push, post-increment on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp_q <= SP_RESET;
        else if (op_push) sp_q <= sp_dec;
        else if (op_pop)  sp_q <= sp_inc;
    end

    // Instruction pointer: control-transfer load wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)          ip_q <= IP_RESET;
        else if (cs_load)    ip_q <= ip_load_val;
        else if (ip_advance) ip_q <= ip_q + AW'(ip_len);
    end

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        op_push |=> ($past(sp_q) - sp_q) == ($past(wide) ? AW'(4) : AW'(2))); // R7
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        op_pop |=> (sp_q - $past(sp_q)) == ($past(wide) ? AW'(4) : AW'(2))); // R8
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_push && !op_pop) |=> $stable(sp_q)); // R8
    AST_IP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_load |=> ip_q == $past(ip_load_val)); // R3
    AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_load && !ip_advance) |=> $stable(ip_q)); // R4
endmodule

// File: rtl/seg_addr_unit.sv
// Segmented address generation unit: picks a segment, adds its base to
// the offset the operation implies, and updates the stack and
// instruction pointers. Addresses are combinational from the current
// state and inputs. Assumes op is held for one cycle per operation.
module seg_addr_unit #(
    parameter int            AW       = 32,
    parameter int            LW       = 4,
    parameter int            DF_BIT   = 10,
    parameter logic [AW-1:0] SP_RESET = '0,
    parameter logic [AW-1:0] IP_RESET = 32'h0000_FFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seg_wr_en,
    input  logic [2:0]    seg_wr_sel,
    input  logic [AW-1:0] seg_wr_base,
    input  logic          cs_load,
    input  logic [AW-1:0] cs_base_in,
    input  logic [AW-1:0] ip_load_val,
    input  logic          ip_advance,
    input  logic [LW-1:0] ip_len,
    input  logic [2:0]    op,
    input  logic          base_is_frame,
    input  logic          ovr_valid,
    input  logic [2:0]    ovr_sel,
    input  logic [AW-1:0] offset,
    input  logic [2:0]    acc_size,
    input  logic [AW-1:0] flags,
    output logic [AW-1:0] lin_addr,
    output logic          addr_valid,
    output logic [AW-1:0] str_ptr_next,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] ip
);
    import agu_pkg::*;

    logic [2:0]    sel;
    logic [AW-1:0] seg_base;
    logic [AW-1:0] code_base;
    logic [AW-1:0] sp_dec;
    logic [AW-1:0] eff_off;
    logic          is_push;
    logic          is_pop;

    assign is_push = (op == OP_PUSH);
    assign is_pop  = (op == OP_POP);

    agu_seg_select #(.NSEG(NUM_SEG)) u_sel (
        .op            (op),
        .base_is_frame (base_is_frame),
        .ovr_valid     (ovr_valid),
        .ovr_sel       (ovr_sel),
        .sel           (sel)
    );

    agu_seg_base_file #(.AW(AW), .NSEG(NUM_SEG)) u_bases (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (seg_wr_en),
        .wr_sel    (seg_wr_sel),
        .wr_base   (seg_wr_base),
        .cs_load   (cs_load),
        .cs_base   (cs_base_in),
        .rd_sel    (sel),
        .rd_base   (seg_base),
        .code_base (code_base)
    );

    agu_ptr_seq #(.AW(AW), .LW(LW), .SP_RESET(SP_RESET), .IP_RESET(IP_RESET)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_push     (is_push),
        .op_pop      (is_pop),
        .wide        (acc_size[2]),
        .cs_load     (cs_load),
        .ip_load_val (ip_load_val),
        .ip_advance  (ip_advance),
        .ip_len      (ip_len),
        .sp_q        (sp),
        .ip_q        (ip),
        .sp_dec      (sp_dec)
    );

    // Offset for the current operation.
    always_comb begin
        case (op)
            OP_FETCH: eff_off = ip;
            OP_PUSH:  eff_off = sp_dec;
            OP_POP:   eff_off = sp;
            default:  eff_off = offset;
        endcase
    end

    assign lin_addr   = seg_base + eff_off;
    assign addr_valid = (op >= OP_FETCH) && (op <= OP_STRING);

    // String pointer step under the direction flag.
    always_comb begin
        if (flags[DF_BIT]) str_ptr_next = offset - AW'(acc_size);
        else               str_ptr_next = offset + AW'(acc_size);
    end

    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FETCH) |-> lin_addr == code_base + ip); // R5
endmodule

// File: tb/seg_addr_unit_tb_top.sv
`timescale 1ns/1ps
module seg_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en;
    logic [2:0]  seg_wr_sel;
    logic [31:0] seg_wr_base;
    logic        cs_load;
    logic [31:0] cs_base_in;
    logic [31:0] ip_load_val;
    logic        ip_advance;
    logic [3:0]  ip_len;
    logic [2:0]  op;
    logic        base_is_frame;
    logic        ovr_valid;
    logic [2:0]  ovr_sel;
    logic [31:0] offset;
    logic [2:0]  acc_size;
    logic [31:0] flags;
    logic [31:0] lin_addr;
    logic        addr_valid;
    logic [31:0] str_ptr_next;
    logic [31:0] sp;
    logic [31:0] ip;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [31:0] m_base [6];
    logic [31:0] m_sp;
    logic [31:0] m_ip;

    always #10 clk = ~clk;

    seg_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_base(seg_wr_base),
        .cs_load(cs_load), .cs_base_in(cs_base_in), .ip_load_val(ip_load_val),
        .ip_advance(ip_advance), .ip_len(ip_len),
        .op(op), .base_is_frame(base_is_frame), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .offset(offset), .acc_size(acc_size), .flags(flags),
        .lin_addr(lin_addr), .addr_valid(addr_valid), .str_ptr_next(str_ptr_next),
        .sp(sp), .ip(ip)
    );

    function automatic int m_seg();
        if (op == 3'd1) return 0;
        if (op == 3'd3 || op == 3'd4) return 2;
        if (ovr_valid && ovr_sel < 3'd6) return int'(ovr_sel);
        if (base_is_frame) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] m_step();
        return acc_size[2] ? 32'd4 : 32'd2;
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare outputs (inputs were driven at the negedge), then advance model.
    task automatic cyc();
        logic [31:0] e_lin;
        #1;
        n_vec++;
        case (op)
            3'd1:    e_lin = m_base[0] + m_ip;
            3'd3:    e_lin = m_base[2] + (m_sp - m_step());
            3'd4:    e_lin = m_base[2] + m_sp;
            default: e_lin = m_base[m_seg()] + offset;
        endcase
        cmp("sp", sp, m_sp);
        cmp("ip", ip, m_ip);
        cmp("addr_valid", {31'd0, addr_valid}, {31'd0, (op >= 3'd1 && op <= 3'd5)});
        if (op != 3'd0) cmp("lin_addr", lin_addr, e_lin);
        cmp("str_ptr_next", str_ptr_next,
            flags[10] ? offset - {29'd0, acc_size} : offset + {29'd0, acc_size});
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_base[i] = 32'd0;
            m_sp = 32'd0;
            m_ip = 32'h0000_FFF0;
        end else begin
            if (seg_wr_en && seg_wr_sel >= 3'd1 && seg_wr_sel <= 3'd5)
                m_base[int'(seg_wr_sel)] = seg_wr_base;
            if (cs_load) begin
                m_base[0] = cs_base_in;
                m_ip = ip_load_val;
            end else if (ip_advance) begin
                m_ip = m_ip + {28'd0, ip_len};
            end
            if (op == 3'd3)      m_sp = m_sp - m_step();
            else if (op == 3'd4) m_sp = m_sp + m_step();
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_base = 0;
        cs_load = 0; cs_base_in = 0; ip_load_val = 0;
        ip_advance = 0; ip_len = 0;
        op = 0; base_is_frame = 0; ovr_valid = 0; ovr_sel = 0;
        offset = 0; acc_size = 3'd4; flags = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) m_base[i] = 32'hDEAD_0000;
        m_sp = 32'hDEAD_0001; m_ip = 32'hDEAD_0002;
        quiet();
        @(negedge clk);
        // R1: reset cycle applies, model takes reset values
        cur_req = "R1"; #1;
        for (int i = 0; i < 6; i++) m_base[i] = 32'd0;
        m_sp = 32'd0; m_ip = 32'h0000_FFF0;
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; op = 3'd1; cyc();

        // R10: push straight from reset wraps the stack pointer
        cur_req = "R10"; op = 3'd3; acc_size = 3'd4; cyc();
        quiet(); cyc();

        // R2: load the five loadable bases
        cur_req = "R2";
        for (int s = 1; s <= 5; s++) begin
            seg_wr_en = 1; seg_wr_sel = 3'(s); seg_wr_base = 32'h1000_0000 * s + 32'h100;
            cyc();
        end
        // R2: code, 6 and 7 ignored; R3 code base untouched
        seg_wr_sel = 3'd0; seg_wr_base = 32'hBAD0_0000; cyc();
        seg_wr_sel = 3'd6; cyc();
        seg_wr_sel = 3'd7; cyc();
        quiet();
        cur_req = "R3"; op = 3'd1; cyc();
        for (int s = 0; s < 6; s++) begin
            cur_req = "R2"; op = 3'd2; ovr_valid = 1; ovr_sel = 3'(s); offset = 32'h44; cyc();
        end
        quiet();

        // R3: control-transfer load, then fetch; R5 fetch ignores override
        cur_req = "R3"; cs_load = 1; cs_base_in = 32'h0002_0000; ip_load_val = 32'h0000_0100; cyc();
        quiet();
        cur_req = "R5"; op = 3'd1; ovr_valid = 1; ovr_sel = 3'd3; cyc();
        // R4: advance
        quiet();
        cur_req = "R4"; ip_advance = 1; ip_len = 4'd7; cyc();
        ip_len = 4'd15; op = 3'd1; cyc();
        quiet(); cur_req = "R4"; cyc();
        // R3: load beats advance in the same cycle
        cur_req = "R3"; cs_load = 1; ip_advance = 1; ip_len = 4'd3;
        cs_base_in = 32'hFFFF_FF00; ip_load_val = 32'hFFFF_FFFE; cyc();
        quiet();
        // R10: fetch address and advance both wrap
        cur_req = "R10"; op = 3'd1; ip_advance = 1; ip_len = 4'd5; cyc();
        op = 3'd1; ip_advance = 0; cyc();
        quiet();

        // R6: defaults and overrides
        cur_req = "R6"; op = 3'd2; offset = 32'h0000_1234; cyc();
        base_is_frame = 1; cyc();
        ovr_valid = 1; ovr_sel = 3'd4; cyc();
        ovr_sel = 3'd6; cyc();
        base_is_frame = 0; ovr_sel = 3'd7; cyc();
        ovr_sel = 3'd0; cyc();
        op = 3'd5; ovr_sel = 3'd5; cyc();
        ovr_valid = 0; base_is_frame = 1; cyc();
        quiet();

        // R7/R8: push and pop order, both sizes, override ignored
        cur_req = "R7"; op = 3'd3; acc_size = 3'd4; cyc();
        op = 3'd3; acc_size = 3'd2; ovr_valid = 1; ovr_sel = 3'd1; cyc();
        quiet();
        cur_req = "R8"; op = 3'd4; acc_size = 3'd2; cyc();
        op = 3'd4; acc_size = 3'd4; ovr_valid = 1; ovr_sel = 3'd3; cyc();
        quiet();
        cur_req = "R8"; op = 3'd2; cyc();
        op = 3'd4; acc_size = 3'd4; cyc();
        quiet();

        // R9: string stepping, both directions and all sizes
        cur_req = "R9"; op = 3'd5; offset = 32'h0000_8000;
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 3; k++) begin
                flags = d[0] ? 32'h0000_0400 : 32'h0000_0002;
                acc_size = 3'(1 << k);
                cyc();
            end
        end
        // R10: string pointer wraps at both ends
        cur_req = "R10"; flags = 32'h0000_0400; offset = 32'd1; acc_size = 3'd4; cyc();
        flags = 32'd0; offset = 32'hFFFF_FFFF; acc_size = 3'd2; cyc();
        // R9: a flag bit other than 10 does not reverse
        cur_req = "R9"; flags = 32'hFFFF_FBFF; offset = 32'h10; cyc();

        // R11: idle drives addr_valid low
        quiet();
        cur_req = "R11"; op = 3'd0; cyc();
        op = 3'd6; cyc();
        op = 3'd7; cyc();
        quiet(); cyc();

        // R1: reset mid-run restores reset values
        cur_req = "R1"; rst_n = 0; cyc();
        rst_n = 1; op = 3'd1; cyc();
        quiet(); cyc();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule